// File: doc/BRIEF.md
# Accumulator Register-Operation Execution Unit

This block carries out the register-only operations of a small accumulator machine in one clock cycle each. It holds a 16-bit accumulator and a one-bit extend flag. Together they form a 17-bit path through which the two rotate operations circulate. It also holds a run flag that a halt operation clears. Four conditional tests (accumulator sign clear, sign set, accumulator zero, extend flag clear) raise a one-cycle skip pulse. The program counter logic uses that pulse to step over the next instruction.

The instruction decoder presents a 12-bit one-hot operation field together with an execute strobe. An operation takes effect at the clock edge where the strobe is high, but only if the field has exactly one bit set and the run flag is set. The new accumulator, extend and run values, and the skip pulse, are visible in the cycle after that edge. Memory access, fetch and opcode decoding are handled elsewhere.

Top module: `acc_rr_exec_unit`

## Requirements
- R1: While reset is asserted, and after its release, the accumulator reads 0, the extend flag reads 0, the skip pulse is low and the run flag is 1.
- R2: Operation bit 11 clears the accumulator, and operation bit 10 clears the extend flag. Each leaves the other register unchanged.
- R3: Operation bit 9 replaces the accumulator with its bitwise inverse, and operation bit 8 inverts the extend flag. Each leaves the other register unchanged.
- R4: Operation bit 7 rotates right through extend. Accumulator bit 0 moves into extend, and the old extend value enters accumulator bit 15.
- R5: Operation bit 6 rotates left through extend. Accumulator bit 15 moves into extend, and the old extend value enters accumulator bit 0.
- R6: Operation bit 5 adds one to the accumulator modulo 2^16, so 0xFFFF becomes 0x0000. The extend flag is unchanged.
- R7: Operation bits 4, 3, 2 and 1 raise the skip output when, respectively, accumulator bit 15 is 0, bit 15 is 1, the whole accumulator is 0, or extend is 0. The skip output is high for exactly the one cycle after the accepted strobe edge, and these tests leave the accumulator and extend unchanged.
- R8: Operation bit 0 clears the run flag. While the run flag is 0, strobes have no effect on any output until reset.
- R9: A strobe whose operation field has zero bits or more than one bit set has no effect, and neither does a set field without the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| exec_stb | input | 1 | Execute strobe, sampled at the rising edge |
| op_sel | input | 12 | One-hot operation field (bit 11 clear-acc down to bit 0 halt) |
| ac_o | output | 16 | Accumulator |
| e_o | output | 1 | Extend flag |
| skip_o | output | 1 | One-cycle skip pulse for the program counter |
| run_o | output | 1 | Run flag; 0 once halted |

## Verification
The bench builds each accumulator value through the block's own ports, by shifting bits in with the left rotate. Every non-halt operation is then applied to every value, once with extend at 0 and once with extend at 1. The values include all zeros, all ones, the single sign bit, the largest positive value, alternating patterns and a pseudo-random set. Together they separate the sign, zero and carry-into-rotation paths, and they expose the wrap of the increment at 0xFFFF. Multi-bit, empty and unstrobed operation fields show that nothing is accepted outside a single clean strobe. Strobes issued after a halt show that the run flag gates everything until reset.

// File: rtl/acc_rr_pkg.sv
package acc_rr_pkg;
  localparam int OP_W = 12;

  // operation field bit positions (one-hot)
  localparam int OP_CLR_AC  = 11;
  localparam int OP_CLR_E   = 10;
  localparam int OP_CPL_AC  = 9;
  localparam int OP_CPL_E   = 8;
  localparam int OP_ROT_R   = 7;
  localparam int OP_ROT_L   = 6;
  localparam int OP_INCR    = 5;
  localparam int OP_SK_POS  = 4;
  localparam int OP_SK_NEG  = 3;
  localparam int OP_SK_ZERO = 2;
  localparam int OP_SK_EZ   = 1;
  localparam int OP_HALT    = 0;

  // sub-field layout handed to the datapath and skip evaluator
  localparam int ALU_W   = OP_CLR_AC - OP_INCR + 1;
  localparam int SKIP_W  = OP_SK_POS - OP_SK_EZ + 1;
  localparam int A_CLR_AC = OP_CLR_AC - OP_INCR;
  localparam int A_CLR_E  = OP_CLR_E  - OP_INCR;
  localparam int A_CPL_AC = OP_CPL_AC - OP_INCR;
  localparam int A_CPL_E  = OP_CPL_E  - OP_INCR;
  localparam int A_ROT_R  = OP_ROT_R  - OP_INCR;
  localparam int A_ROT_L  = OP_ROT_L  - OP_INCR;
  localparam int A_INCR   = 0;
  localparam int S_POS    = OP_SK_POS  - OP_SK_EZ;
  localparam int S_NEG    = OP_SK_NEG  - OP_SK_EZ;
  localparam int S_ZERO   = OP_SK_ZERO - OP_SK_EZ;
  localparam int S_EZ     = 0;
endpackage

// File: rtl/acc_rr_decode.sv
module acc_rr_decode
  import acc_rr_pkg::*;
(
  input  logic              exec_stb,
  input  logic [OP_W-1:0]   op_sel,
  input  logic              run,
  output logic              op_accept,
  output logic [ALU_W-1:0]  alu_cmd,
  output logic [SKIP_W-1:0] skip_cmd,
  output logic              halt_cmd
);
  logic             field_onehot;
  logic [OP_W-1:0]  gated;

  assign field_onehot = $onehot(op_sel);
  assign op_accept    = exec_stb && run && field_onehot;
  assign gated        = op_accept ? op_sel : '0;

  assign alu_cmd  = gated[OP_CLR_AC:OP_INCR];
  assign skip_cmd = gated[OP_SK_POS:OP_SK_EZ];
  assign halt_cmd = gated[OP_HALT];
endmodule

// File: rtl/acc_rr_alu.sv
module acc_rr_alu
  import acc_rr_pkg::*;
#(
  parameter int AC_W = 16
) (
  input  logic [ALU_W-1:0] cmd,
  input  logic [AC_W-1:0]  ac,
  input  logic             e,
  output logic [AC_W-1:0]  ac_nxt,
  output logic             e_nxt
);
  localparam int PATH_W = AC_W + 1;

  // rotate the combined {e, ac} path one place right
  function automatic logic [PATH_W-1:0] rot_right(input logic [PATH_W-1:0] p);
    return {p[0], p[PATH_W-1:1]};
  endfunction

  // rotate the combined {e, ac} path one place left
  function automatic logic [PATH_W-1:0] rot_left(input logic [PATH_W-1:0] p);
    return {p[PATH_W-2:0], p[PATH_W-1]};
  endfunction

  function automatic logic [AC_W-1:0] wrap_inc(input logic [AC_W-1:0] v);
    return v + AC_W'(1);
  endfunction

  logic [PATH_W-1:0] path_now, path_r, path_l;

  assign path_now = {e, ac};
  assign path_r   = rot_right(path_now);
  assign path_l   = rot_left(path_now);

  always_comb begin
    ac_nxt = ac;
    e_nxt  = e;
    if (cmd[A_CLR_AC]) ac_nxt = '0;
    if (cmd[A_CLR_E])  e_nxt  = 1'b0;
    if (cmd[A_CPL_AC]) ac_nxt = ~ac;
    if (cmd[A_CPL_E])  e_nxt  = ~e;
    if (cmd[A_ROT_R])  {e_nxt, ac_nxt} = path_r;
    if (cmd[A_ROT_L])  {e_nxt, ac_nxt} = path_l;
    if (cmd[A_INCR])   ac_nxt = wrap_inc(ac);
  end
endmodule

// File: rtl/acc_rr_skip_eval.sv
module acc_rr_skip_eval
  import acc_rr_pkg::*;
#(
  parameter int AC_W = 16
) (
  input  logic [SKIP_W-1:0] cmd,
  input  logic [AC_W-1:0]   ac,
  input  logic              e,
  output logic              skip_hit
);
  logic sign_bit, ac_zero;

  assign sign_bit = ac[AC_W-1];
  assign ac_zero  = (ac == '0);

  assign skip_hit = (cmd[S_POS]  && !sign_bit) ||
                    (cmd[S_NEG]  &&  sign_bit) ||
                    (cmd[S_ZERO] &&  ac_zero)  ||
                    (cmd[S_EZ]   && !e);
endmodule

// File: rtl/acc_rr_exec_unit.sv
module acc_rr_exec_unit
  import acc_rr_pkg::*;
#(
  parameter int AC_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            exec_stb,
  input  logic [OP_W-1:0] op_sel,
  output logic [AC_W-1:0] ac_o,
  output logic            e_o,
  output logic            skip_o,
  output logic            run_o
);
  logic [AC_W-1:0]   ac_q, ac_nxt;
  logic              e_q, e_nxt;
  logic              skip_q, run_q;
  logic              op_accept;
  logic [ALU_W-1:0]  alu_cmd;
  logic [SKIP_W-1:0] skip_cmd;
  logic              halt_cmd;
  logic              skip_hit;

  acc_rr_decode u_dec (
    .exec_stb (exec_stb),
    .op_sel   (op_sel),
    .run      (run_q),
    .op_accept(op_accept),
    .alu_cmd  (alu_cmd),
    .skip_cmd (skip_cmd),
    .halt_cmd (halt_cmd)
  );

  acc_rr_alu #(.AC_W(AC_W)) u_alu (
    .cmd   (alu_cmd),
    .ac    (ac_q),
    .e     (e_q),
    .ac_nxt(ac_nxt),
    .e_nxt (e_nxt)
  );

  acc_rr_skip_eval #(.AC_W(AC_W)) u_skip (
    .cmd     (skip_cmd),
    .ac      (ac_q),
    .e       (e_q),
    .skip_hit(skip_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ac_q   <= '0;
      e_q    <= 1'b0;
      skip_q <= 1'b0;
      run_q  <= 1'b1;
    end else begin
      ac_q   <= ac_nxt;
      e_q    <= e_nxt;
      skip_q <= skip_hit;
      if (halt_cmd) run_q <= 1'b0;
    end
  end

  assign ac_o   = ac_q;
  assign e_o    = e_q;
  assign skip_o = skip_q;
  assign run_o  = run_q;
endmodule

// File: rtl/acc_rr_exec_chk.sv
module acc_rr_exec_chk
  import acc_rr_pkg::*;
#(
  parameter int AC_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            exec_stb,
  input logic [OP_W-1:0] op_sel,
  input logic [AC_W-1:0] ac_o,
  input logic            e_o,
  input logic            skip_o,
  input logic            run_o,
  input logic            op_accept
);
  a_r2_clear_ac: assert property (@(posedge clk) disable iff (!rst_n)
    op_accept && op_sel[OP_CLR_AC] |=> ac_o == '0 && e_o == $past(e_o));

  a_r3_invert_ac: assert property (@(posedge clk) disable iff (!rst_n)
    op_accept && op_sel[OP_CPL_AC] |=> ac_o == ~$past(ac_o));

  a_r4_rot_right_e: assert property (@(posedge clk) disable iff (!rst_n)
    op_accept && op_sel[OP_ROT_R] |=> e_o == $past(ac_o[0]) && ac_o[AC_W-1] == $past(e_o));

  a_r5_rot_left_e: assert property (@(posedge clk) disable iff (!rst_n)
    op_accept && op_sel[OP_ROT_L] |=> e_o == $past(ac_o[AC_W-1]) && ac_o[0] == $past(e_o));

  a_r6_inc_step: assert property (@(posedge clk) disable iff (!rst_n)
    op_accept && op_sel[OP_INCR] |=> (ac_o - $past(ac_o)) == AC_W'(1) && $stable(e_o));

  a_r7_skip_only_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    skip_o |-> $past(op_accept));

  a_r7_skip_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
    op_accept && (op_sel[OP_SK_POS:OP_SK_EZ] != '0) |=> $stable(ac_o) && $stable(e_o));

  a_r8_halt_clears_run: assert property (@(posedge clk) disable iff (!rst_n)
    op_accept && op_sel[OP_HALT] |=> !run_o);

  a_r8_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !run_o |=> !run_o && $stable(ac_o) && $stable(e_o) && !skip_o);

  a_r9_bad_field_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    exec_stb && !$onehot(op_sel) |=> $stable(ac_o) && $stable(e_o) && !skip_o);
endmodule

bind acc_rr_exec_unit acc_rr_exec_chk #(.AC_W(AC_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .exec_stb (exec_stb),
  .op_sel   (op_sel),
  .ac_o     (ac_o),
  .e_o      (e_o),
  .skip_o   (skip_o),
  .run_o    (run_o),
  .op_accept(op_accept)
);

// File: tb/acc_rr_exec_unit_tb.sv
module acc_rr_exec_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exec_stb = 1'b0;
  logic [11:0] op_sel = '0;
  logic [15:0] ac_o;
  logic        e_o, skip_o, run_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [15:0] m_ac;
  logic        m_e, m_run;

  always #5 clk = ~clk;

  acc_rr_exec_unit #(.AC_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .exec_stb(exec_stb), .op_sel(op_sel),
    .ac_o(ac_o), .e_o(e_o), .skip_o(skip_o), .run_o(run_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic [11:0] sel, input logic stb, input string req);
    logic acc, ee, erun, esk;
    logic [15:0] eac;
    acc  = stb && m_run && ($countones(sel) == 1);
    eac  = m_ac; ee = m_e; erun = m_run; esk = 1'b0;
    if (acc) begin
      case (sel)
        12'h800: eac = 16'h0000;
        12'h400: ee  = 1'b0;
        12'h200: eac = 16'(32'hFFFF - 32'(m_ac));
        12'h100: ee  = !m_e;
        12'h080: begin eac = 16'(32'(m_ac) / 2 + (m_e ? 32'h8000 : 32'h0)); ee = m_ac[0]; end
        12'h040: begin eac = 16'((32'(m_ac) * 2 + 32'(m_e)) % 65536); ee = m_ac[15]; end
        12'h020: eac = 16'((32'(m_ac) + 1) % 65536);
        12'h010: esk = (m_ac < 16'h8000);
        12'h008: esk = (m_ac >= 16'h8000);
        12'h004: esk = (m_ac == 16'h0000);
        12'h002: esk = !m_e;
        12'h001: erun = 1'b0;
        default: ;
      endcase
    end
    @(negedge clk); op_sel = sel; exec_stb = stb;
    @(negedge clk); op_sel = '0; exec_stb = 1'b0;
    chk(ac_o == eac, req, "ac", int'(ac_o), int'(eac));
    chk(e_o == ee, req, "e", int'(e_o), int'(ee));
    chk(skip_o == esk, req, "skip", int'(skip_o), int'(esk));
    chk(run_o == erun, req, "run", int'(run_o), int'(erun));
    m_ac = eac; m_e = ee; m_run = erun;
    if (esk) begin
      @(negedge clk);
      chk(skip_o == 1'b0, "R7", "skip pulse length", int'(skip_o), 0);
    end
  endtask

  // shift the wanted value in through extend with left rotates
  task automatic load_ac(input logic [15:0] v, input logic ev);
    step(12'h800, 1'b1, "R2");
    for (int i = 15; i >= 0; i--) begin
      step(12'h400, 1'b1, "R2");
      if (v[i]) step(12'h100, 1'b1, "R3");
      step(12'h040, 1'b1, "R5");
    end
    step(12'h400, 1'b1, "R2");
    if (ev) step(12'h100, 1'b1, "R3");
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(ac_o == 0 && e_o == 0 && skip_o == 0 && run_o == 1, "R1", "state in reset",
        int'({ac_o, e_o, skip_o, run_o}), 1);
    rst_n = 1'b1;
    m_ac = '0; m_e = 1'b0; m_run = 1'b1;
    @(negedge clk);
    chk(ac_o == 0, "R1", "ac after reset", int'(ac_o), 0);
    chk(e_o == 0, "R1", "e after reset", int'(e_o), 0);
    chk(skip_o == 0, "R1", "skip after reset", int'(skip_o), 0);
    chk(run_o == 1, "R1", "run after reset", int'(run_o), 1);
  endtask

  function automatic string op_req(input int k);
    case (k)
      0, 1: return "R2";
      2, 3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      default: return "R7";
    endcase
  endfunction

  initial begin
    logic [15:0] vals [32];
    logic [15:0] lfsr;
    vals[0] = 16'h0000; vals[1] = 16'hFFFF; vals[2] = 16'h8000; vals[3] = 16'h7FFF;
    vals[4] = 16'h0001; vals[5] = 16'hAAAA; vals[6] = 16'h5555; vals[7] = 16'hFFFE;
    lfsr = 16'hACE1;
    for (int i = 8; i < 32; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      vals[i] = lfsr;
    end

    do_reset();

    // every non-halt operation against every value, extend 0 and 1
    for (int v = 0; v < 32; v++) begin
      for (int ev = 0; ev < 2; ev++) begin
        for (int k = 0; k < 11; k++) begin
          load_ac(vals[v], ev[0]);
          step(12'h800 >> k, 1'b1, op_req(k));
        end
      end
    end

    // R6: wrap of increment at all ones
    load_ac(16'hFFFF, 1'b1);
    step(12'h020, 1'b1, "R6");
    chk(ac_o == 16'h0000 && e_o == 1'b1, "R6", "wrap", int'(ac_o), 0);

    // R9: malformed or unstrobed fields
    load_ac(16'h1234, 1'b0);
    step(12'h0C0, 1'b1, "R9");
    step(12'h000, 1'b1, "R9");
    step(12'h200, 1'b0, "R9");
    step(12'h811, 1'b1, "R9");
    step(12'h012, 1'b1, "R9");

    // R8: halt then attempts while stopped
    step(12'h001, 1'b1, "R8");
    step(12'h200, 1'b1, "R8");
    step(12'h800, 1'b1, "R8");
    step(12'h002, 1'b1, "R8");
    step(12'h020, 1'b1, "R8");
    chk(ac_o == 16'h1234, "R8", "ac held while halted", int'(ac_o), 16'h1234);

    do_reset();
    step(12'h020, 1'b1, "R6");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule